// File: doc/BRIEF.md
# CAN Operating Mode Handshake Controller

This block ties the mode requests that software writes for a CAN controller to the operating mode the hardware is actually in. Software raises an initialization request or a sleep request. The block moves into the requested mode and reports it on an acknowledge output. When a request is withdrawn, the acknowledge is held until the controller has synchronized to the bus. Synchronization means eleven consecutive recessive bits have been sampled on the receive line, at the bit-time strobe.

A second, smaller function gathers error-detection pulses into a single error interrupt flag. Each source is gated by its own enable. Software clears the flag with a write-one-to-clear strobe. A registered status-change interrupt line is driven while the flag is set and the error interrupt enable is on.

Top module: `canmode_ctrl`

## Requirements
- R1: In the cycle after synchronous reset is released, init_ack is 1, sleep_ack is 0, err_flag is 0 and status_irq is 0.
- R2: When init_req is 1 at a clock edge, init_ack is 1 and sleep_ack is 0 after that edge, whatever the mode before.
- R3: After init_req is seen low in initialization mode, init_ack stays 1 until the edge that samples the eleventh consecutive recessive bit, and falls at that edge. A recessive bit is rx_line = 1 with bit_tick = 1. Counting starts with the edge after the one that saw the request drop.
- R4: A dominant sample (rx_line = 0 with bit_tick = 1) restarts the recessive count from zero. A cycle without bit_tick does not change the count.
- R5: In normal mode, sleep_req = 1 with init_req = 0 at an edge sets sleep_ack and leaves init_ack at 0 after that edge.
- R6: After sleep_req is seen low in sleep mode, sleep_ack stays 1 until the edge that samples the eleventh consecutive recessive bit, and falls at that edge. Counting starts with the edge after the one that saw the request drop.
- R7: When init_req and sleep_req are both 1, initialization mode is entered (init_ack 1, sleep_ack 0). This holds from sleep mode as well.
- R8: If a request is raised again while the block is leaving that mode, the block returns to the mode with its acknowledge held, and the next exit needs a fresh run of eleven recessive bits.
- R9: err_flag is 1 after any edge at which err_set[i] and err_src_en[i] are both 1, for some i. A pulse on a source whose enable is 0 leaves err_flag unchanged.
- R10: flag_wr = 1 with flag_wr_data = 1 clears err_flag at the next edge. With flag_wr_data = 0 the write has no effect. An enabled error pulse in the same cycle as a clear wins, and the flag stays 1.
- R11: status_irq is a register equal to the updated err_flag ANDed with err_ien as sampled at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Software initialization request |
| sleep_req | input | 1 | Software sleep request |
| rx_line | input | 1 | Sampled CAN receive line, 1 = recessive |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| err_set | input | NERR | Error-detection set pulses, one per source |
| err_src_en | input | NERR | Per-source error interrupt enables |
| err_ien | input | 1 | Error interrupt enable for the status-change line |
| flag_wr | input | 1 | Single-cycle write strobe for the error flag |
| flag_wr_data | input | 1 | Write data, 1 clears the error flag |
| init_ack | output | 1 | Initialization mode acknowledge |
| sleep_ack | output | 1 | Sleep mode acknowledge |
| err_flag | output | 1 | Error interrupt flag |
| status_irq | output | 1 | Status-change interrupt line |

## Verification
Several properties are checked on every cycle:
- The two acknowledges are never high together.
- An initialization request always yields init_ack on the next cycle.
- An acknowledge falls only one cycle after the synchronization counter reported its eleventh recessive bit.
- A dominant sample empties the count, and a cycle without a tick leaves it alone.
- The error flag follows enabled pulses and clears.
- status_irq never stands without the flag.

Some behaviours only the bench's scenarios can show:
- The exact edge at which an acknowledge falls after a full run of ticks.
- That ticks seen in the cycle of the request drop are not counted.
- That a request raised again in mid-exit forces a whole new run.
- That a write of 0, or a disabled source, leaves the flag alone.

// File: rtl/canmode_pkg.sv
package canmode_pkg;
  typedef enum logic [2:0] {
    MD_INIT,
    MD_LEAVE_INIT,
    MD_ACTIVE,
    MD_SLEEP,
    MD_LEAVE_SLEEP
  } mode_e;
endpackage

// File: rtl/canmode_sync_cnt.sv
module canmode_sync_cnt #(
  parameter int SYNC_BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic rx,
  output logic sync_hit
);
  localparam int CW = $clog2(SYNC_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(SYNC_BITS - 1);

  logic [CW-1:0] cnt;

  assign sync_hit = run && tick && rx && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      if (!rx || sync_hit) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
    end
  end

  // R4
  cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !rx) |=> (cnt == '0));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/canmode_fsm.sv
module canmode_fsm
  import canmode_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic init_req,
  input  logic sleep_req,
  input  logic sync_hit,
  output logic syncing,
  output logic init_ack,
  output logic sleep_ack
);
  mode_e state, nxt;

  always_comb begin
    nxt = state;
    case (state)
      MD_INIT: begin
        if (init_req)       nxt = MD_INIT;
        else if (sleep_req) nxt = MD_SLEEP;
        else                nxt = MD_LEAVE_INIT;
      end
      MD_LEAVE_INIT: begin
        if (init_req)      nxt = MD_INIT;
        else if (sync_hit) nxt = MD_ACTIVE;
      end
      MD_ACTIVE: begin
        if (init_req)       nxt = MD_INIT;
        else if (sleep_req) nxt = MD_SLEEP;
      end
      MD_SLEEP: begin
        if (init_req)        nxt = MD_INIT;
        else if (!sleep_req) nxt = MD_LEAVE_SLEEP;
      end
      MD_LEAVE_SLEEP: begin
        if (init_req)       nxt = MD_INIT;
        else if (sleep_req) nxt = MD_SLEEP;
        else if (sync_hit)  nxt = MD_ACTIVE;
      end
      default: nxt = MD_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= MD_INIT;
      init_ack  <= 1'b1;
      sleep_ack <= 1'b0;
    end else begin
      state     <= nxt;
      init_ack  <= (nxt == MD_INIT)  || (nxt == MD_LEAVE_INIT);
      sleep_ack <= (nxt == MD_SLEEP) || (nxt == MD_LEAVE_SLEEP);
    end
  end

  assign syncing = (state == MD_LEAVE_INIT) || (state == MD_LEAVE_SLEEP);

  // R7
  ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(init_ack && sleep_ack));

  // R2
  req_init_chk: assert property (@(posedge clk) disable iff (rst)
    init_req |=> (init_ack && !sleep_ack));

  // R3
  init_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(init_ack) && !sleep_ack) |-> $past(sync_hit));

  // R6
  sleep_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sleep_ack) && !init_ack) |-> $past(sync_hit));
endmodule

// File: rtl/canmode_err_irq.sv
module canmode_err_irq #(
  parameter int NERR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NERR-1:0] err_set,
  input  logic [NERR-1:0] err_src_en,
  input  logic            err_ien,
  input  logic            flag_wr,
  input  logic            flag_wr_data,
  output logic            err_flag,
  output logic            status_irq
);
  logic set_any, clr, flag_nxt;

  assign set_any  = |(err_set & err_src_en);
  assign clr      = flag_wr && flag_wr_data;
  assign flag_nxt = set_any ? 1'b1 : (clr ? 1'b0 : err_flag);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag   <= 1'b0;
      status_irq <= 1'b0;
    end else begin
      err_flag   <= flag_nxt;
      status_irq <= flag_nxt && err_ien;
    end
  end

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|(err_set & err_src_en)) |=> err_flag);

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && flag_wr_data && !(|(err_set & err_src_en))) |=> !err_flag);

  // R11
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    status_irq |-> err_flag);

  // R11
  irq_en_chk: assert property (@(posedge clk) disable iff (rst)
    status_irq |-> $past(err_ien));
endmodule

// File: rtl/canmode_ctrl.sv
module canmode_ctrl #(
  parameter int SYNC_BITS = 11,
  parameter int NERR      = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init_req,
  input  logic            sleep_req,
  input  logic            rx_line,
  input  logic            bit_tick,
  input  logic [NERR-1:0] err_set,
  input  logic [NERR-1:0] err_src_en,
  input  logic            err_ien,
  input  logic            flag_wr,
  input  logic            flag_wr_data,
  output logic            init_ack,
  output logic            sleep_ack,
  output logic            err_flag,
  output logic            status_irq
);
  logic syncing, sync_hit;

  canmode_sync_cnt #(.SYNC_BITS(SYNC_BITS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .run      (syncing),
    .tick     (bit_tick),
    .rx       (rx_line),
    .sync_hit (sync_hit)
  );

  canmode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .init_req  (init_req),
    .sleep_req (sleep_req),
    .sync_hit  (sync_hit),
    .syncing   (syncing),
    .init_ack  (init_ack),
    .sleep_ack (sleep_ack)
  );

  canmode_err_irq #(.NERR(NERR)) u_err (
    .clk          (clk),
    .rst          (rst),
    .err_set      (err_set),
    .err_src_en   (err_src_en),
    .err_ien      (err_ien),
    .flag_wr      (flag_wr),
    .flag_wr_data (flag_wr_data),
    .err_flag     (err_flag),
    .status_irq   (status_irq)
  );
endmodule

// File: tb/tb_canmode_ctrl.sv
module tb_canmode_ctrl;
  localparam int NERR = 4;
  localparam int NV   = 35;
  // {init_req, sleep_req, rx_line, bit_tick, exp_init_ack, exp_sleep_ack}
  localparam logic [5:0] VEC [0:NV-1] = '{
    6'b101110, 6'b001110,
    6'b001110, 6'b001110, 6'b001110, 6'b001110, 6'b001110,
    6'b000110, 6'b001010,
    6'b001110, 6'b001110, 6'b001110, 6'b001110, 6'b001110,
    6'b001110, 6'b001110, 6'b001110, 6'b001110, 6'b001110,
    6'b001100,
    6'b011101, 6'b001101,
    6'b001101, 6'b001101, 6'b001101, 6'b001101, 6'b001101,
    6'b001101, 6'b001101, 6'b001101, 6'b001101, 6'b001101,
    6'b001100,
    6'b111010, 6'b111010
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_req = 1'b0, sleep_req = 1'b0, rx_line = 1'b1, bit_tick = 1'b0;
  logic [NERR-1:0] err_set = '0, err_src_en = '0;
  logic err_ien = 1'b0, flag_wr = 1'b0, flag_wr_data = 1'b0;
  logic init_ack, sleep_ack, err_flag, status_irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  canmode_ctrl #(.SYNC_BITS(11), .NERR(NERR)) dut (
    .clk(clk), .rst(rst), .init_req(init_req), .sleep_req(sleep_req),
    .rx_line(rx_line), .bit_tick(bit_tick), .err_set(err_set),
    .err_src_en(err_src_en), .err_ien(err_ien), .flag_wr(flag_wr),
    .flag_wr_data(flag_wr_data), .init_ack(init_ack), .sleep_ack(sleep_ack),
    .err_flag(err_flag), .status_irq(status_irq)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string req_of(input int i);
    if (i == 0) return "R2";
    if (i <= 6) return "R3";
    if (i <= 8) return "R4";
    if (i <= 19) return "R3";
    if (i == 20) return "R5";
    if (i <= 32) return "R6";
    return "R7";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    rst = 1'b0;
    step();
    chk("R1", "init_ack", init_ack, 1'b1);
    chk("R1", "sleep_ack", sleep_ack, 1'b0);
    chk("R1", "err_flag", err_flag, 1'b0);
    chk("R1", "status_irq", status_irq, 1'b0);

    for (int i = 0; i < NV; i++) begin
      {init_req, sleep_req, rx_line, bit_tick} = VEC[i][5:2];
      step();
      chk(req_of(i), $sformatf("row %0d init_ack", i), init_ack, VEC[i][1]);
      chk(req_of(i), $sformatf("row %0d sleep_ack", i), sleep_ack, VEC[i][0]);
    end

    // R8: re-request during exit restarts the synchronization
    init_req = 1'b0; sleep_req = 1'b0; rx_line = 1'b1; bit_tick = 1'b0;
    step();
    bit_tick = 1'b1;
    repeat (5) step();
    chk("R8", "mid-exit init_ack", init_ack, 1'b1);
    init_req = 1'b1; bit_tick = 1'b0;
    step();
    chk("R8", "re-request init_ack", init_ack, 1'b1);
    init_req = 1'b0;
    step();
    bit_tick = 1'b1;
    repeat (10) step();
    chk("R8", "after 10 fresh bits", init_ack, 1'b1);
    step();
    chk("R8", "after 11 fresh bits", init_ack, 1'b0);
    bit_tick = 1'b0;

    // R9: disabled source ignored
    err_ien = 1'b1; err_set = 4'b0001; err_src_en = 4'b0000;
    step();
    chk("R9", "disabled source flag", err_flag, 1'b0);
    err_set = 4'b0010; err_src_en = 4'b0010;
    step();
    chk("R9", "enabled source flag", err_flag, 1'b1);
    chk("R11", "irq with enable", status_irq, 1'b1);
    // R10: write of 0 has no effect
    err_set = '0; flag_wr = 1'b1; flag_wr_data = 1'b0;
    step();
    chk("R10", "write 0 flag", err_flag, 1'b1);
    flag_wr_data = 1'b1;
    step();
    chk("R10", "write 1 flag", err_flag, 1'b0);
    chk("R11", "irq after clear", status_irq, 1'b0);
    flag_wr = 1'b0; flag_wr_data = 1'b0;
    // R11: enable off masks the line
    err_ien = 1'b0; err_set = 4'b0010;
    step();
    chk("R11", "flag with enable off", err_flag, 1'b1);
    chk("R11", "irq with enable off", status_irq, 1'b0);
    err_set = '0; err_ien = 1'b1;
    step();
    chk("R11", "irq after enable on", status_irq, 1'b1);
    // R10: set wins over simultaneous clear
    flag_wr = 1'b1; flag_wr_data = 1'b1; err_set = 4'b0010;
    step();
    chk("R10", "set beats clear", err_flag, 1'b1);
    err_set = '0;
    step();
    chk("R10", "clear alone", err_flag, 1'b0);
    flag_wr = 1'b0; flag_wr_data = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule